// File: doc/BRIEF.md
# Triggered DMA Channel Sequencer

This block is one channel of a DMA controller that works in dual-address mode. Each data unit is moved in two steps. The channel first reads the unit from a source address, then writes the same value to a destination address. An external trigger starts the work. A two-bit mode field decides how much work one trigger starts: one unit, everything left on the transfer counter, or one block of a programmed length. All three modes share the same transfer counter. When the counter reaches zero, the channel turns itself off and raises a done pulse.

Software programs the channel through a small register port while the channel is disabled. Setting the enable bit starts the channel. The unit size is byte or half-word. Word units are also available, but only when the advanced-mode bit is set. After every unit, both addresses move forward by the unit size. The master side is a request/acknowledge bus that carries a size code with each access.

Top module: `dma_seq_top`

## Requirements
- R1: Mode 00 is single transfer, and it is the reset value of the mode field. Each accepted trigger moves exactly one unit and lowers the counter by one.
- R2: Mode 01 is successive transfer. One trigger moves units back to back until the counter is zero.
- R3: Mode 10 is block transfer. One trigger moves block-length units, where a block length of 0 means 256 units. The counter drops by one per finished block.
- R4: While the advanced bit is 0, the half bit selects the unit size: 0 gives a byte (bus size code 0) and 1 gives a half-word (code 1). The word bit has no effect.
- R5: While the advanced bit is 1 and the word bit is 1, units are 32-bit words (code 2), whatever the half bit holds. With the word bit at 0, R4 applies.
- R6: Each unit is a read of the source address, then a write of the value just read to the destination address. After the write completes, both addresses advance by 1, 2 or 4.
- R7: Mode 11 behaves exactly like mode 00.
- R8: The register index selects the target: 0 is control, 1 is block length, 2 is counter, 3 is source, 4 is destination. Control holds the enable in bit 0, dual in bit 1, mode in bits 3:2, half in bit 4, word in bit 5 and advanced in bit 6. Writes have effect only while the enable is 0.
- R9: When the counter reaches zero, the channel clears its enable in the same cycle as the final write acknowledge. It pulses done_o for one cycle and ignores any later trigger.
- R10: A trigger that arrives while a job is running is held as pending. Any number of such triggers collapse into one pending job.
- R11: The dual bit resets to 0. While it is 0, triggers start nothing.
- R12: The request, address and direction stay stable from request until acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 3 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| trig_i | input | 1 | Transfer trigger, one cycle |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Byte address |
| bus_size_o | output | 2 | 0 byte, 1 half-word, 2 word |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data |
| bus_ack_i | input | 1 | Access complete |
| en_o | output | 1 | Channel enable state |
| done_o | output | 1 | Counter-reached-zero pulse |

## Verification
The hardest case to reach is a pending trigger that coincides with a job ending, because whether that trigger is honoured depends on the counter value at that moment. The stimulus sends a burst of triggers into the read and write phases of a running single-mode job. The scoreboard must then see exactly one extra unit, with the channel still enabled. A final trigger after that must finish the count. Block length 0 is also run end to end, and all 256 unit pairs are checked by address.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SUCC   = 2'b01,
    MODE_BLOCK  = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef struct packed {
    logic  adv;
    logic  word;
    logic  half;
    mode_e mode;
    logic  dual;
    logic  en;
  } ctrl_t;

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_BLK  = 3'd1;
  localparam logic [2:0] IDX_CNT  = 3'd2;
  localparam logic [2:0] IDX_SRC  = 3'd3;
  localparam logic [2:0] IDX_DST  = 3'd4;
endpackage

// File: rtl/dma_size_dec.sv
module dma_size_dec
  import dma_seq_pkg::*;
(
  input  logic       adv_i,
  input  logic       word_i,
  input  logic       half_i,
  output size_e      size_o,
  output logic [2:0] step_o
);
  always_comb begin
    if (adv_i && word_i) size_o = SZ_WORD;
    else if (half_i)     size_o = SZ_HALF;
    else                 size_o = SZ_BYTE;
    step_o = 3'd1 << size_o;
  end
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    idx_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          unit_done_i,
  input  logic [2:0]    step_i,
  input  logic          cnt_dec_i,
  input  logic          stop_i,
  output ctrl_t         ctrl_o,
  output logic [BW-1:0] blk_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o
);
  localparam int CTRL_W = $bits(ctrl_t);
  logic [AW-1:0] step_ext;
  assign step_ext = {{(AW-3){1'b0}}, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      blk_o  <= '0;
      cnt_o  <= '0;
      src_o  <= '0;
      dst_o  <= '0;
    end else if (we_i && !ctrl_o.en) begin
      case (idx_i)
        IDX_CTRL: ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        IDX_BLK:  blk_o  <= wdata_i[BW-1:0];
        IDX_CNT:  cnt_o  <= wdata_i[CW-1:0];
        IDX_SRC:  src_o  <= wdata_i;
        IDX_DST:  dst_o  <= wdata_i;
        default: ;
      endcase
    end else begin
      if (unit_done_i) begin
        src_o <= src_o + step_ext;
        dst_o <= dst_o + step_ext;
      end
      if (cnt_dec_i) cnt_o <= cnt_o - 1'b1;
      if (stop_i)    ctrl_o.en <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_seq_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dual_i,
  input  mode_e         mode_i,
  input  logic [BW-1:0] blk_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          trig_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [DW-1:0] data_o,
  output logic          unit_done_o,
  output logic          cnt_dec_o,
  output logic          stop_o,
  output logic          done_o
);
  localparam int LW = BW + 1;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  st_e           st_q;
  logic          pend_q;
  logic [LW-1:0] left_q;
  logic [LW-1:0] blk_init;
  mode_e         mode_eff;
  logic          go_ok, wr_fin, last_unit, job_end, cnt_one;

  assign mode_eff = (mode_i == MODE_RSVD) ? MODE_SINGLE : mode_i;
  assign blk_init = (blk_i == '0) ? LW'(1 << BW) : {1'b0, blk_i};
  assign go_ok    = en_i && dual_i && (cnt_i != '0);
  assign cnt_one  = (cnt_i == CW'(1));
  assign wr_fin   = (st_q == ST_WR) && ack_i;

  always_comb begin
    case (mode_eff)
      MODE_SUCC:  last_unit = cnt_one;
      MODE_BLOCK: last_unit = (left_q == LW'(1));
      default:    last_unit = 1'b1;
    endcase
  end

  assign job_end     = wr_fin && last_unit;
  assign unit_done_o = wr_fin;
  assign cnt_dec_o   = wr_fin && ((mode_eff != MODE_BLOCK) || (left_q == LW'(1)));
  assign stop_o      = cnt_dec_o && cnt_one;
  assign req_o       = (st_q != ST_IDLE);
  assign we_o        = (st_q == ST_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      left_q <= '0;
      data_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= stop_o;
      if (job_end)                         pend_q <= 1'b0;
      else if (trig_i && st_q != ST_IDLE)  pend_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (trig_i && go_ok) begin
          st_q   <= ST_RD;
          left_q <= blk_init;
        end
        ST_RD: if (ack_i) begin
          data_o <= rdata_i;
          st_q   <= ST_WR;
        end
        ST_WR: if (ack_i) begin
          if (!last_unit) begin
            st_q   <= ST_RD;
            left_q <= left_q - 1'b1;
          end else if (stop_o) begin
            st_q <= ST_IDLE;
          end else if (pend_q || trig_i) begin
            st_q   <= ST_RD;
            left_q <= blk_init;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_idx_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          trig_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [AW-1:0] bus_wdata_o,
  input  logic [AW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  output logic          en_o,
  output logic          done_o
);
  ctrl_t         ctrl_q;
  logic [BW-1:0] blk_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q;
  logic [2:0]    step;
  size_e         size;
  logic          unit_done, cnt_dec, stop;
  logic          cfg_adv;

  assign cfg_adv = ctrl_q.adv;

  dma_cfg_regs #(.AW(AW), .CW(CW), .BW(BW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .unit_done_i(unit_done), .step_i(step), .cnt_dec_i(cnt_dec), .stop_i(stop),
    .ctrl_o(ctrl_q), .blk_o(blk_q), .cnt_o(cnt_q), .src_o(src_q), .dst_o(dst_q)
  );

  dma_size_dec u_size (
    .adv_i(ctrl_q.adv), .word_i(ctrl_q.word), .half_i(ctrl_q.half),
    .size_o(size), .step_o(step)
  );

  dma_xfer_fsm #(.DW(AW), .CW(CW), .BW(BW)) u_fsm (
    .clk_i, .rst_ni,
    .en_i(ctrl_q.en), .dual_i(ctrl_q.dual), .mode_i(ctrl_q.mode),
    .blk_i(blk_q), .cnt_i(cnt_q), .trig_i(trig_i),
    .ack_i(bus_ack_i), .rdata_i(bus_rdata_i),
    .req_o(bus_req_o), .we_o(bus_we_o), .data_o(bus_wdata_o),
    .unit_done_o(unit_done), .cnt_dec_o(cnt_dec), .stop_o(stop), .done_o(done_o)
  );

  assign bus_addr_o = bus_we_o ? dst_q : src_q;
  assign bus_size_o = size;
  assign en_o       = ctrl_q.en;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_ack_i,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_size_o,
  input logic          en_o,
  input logic          done_o,
  input logic          adv_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)); // R12
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && bus_ack_i |=> bus_req_o && bus_we_o); // R6
  AST_DONE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !en_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_OFF_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !bus_req_o); // R9
  AST_WORD_NEEDS_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_size_o == 2'd2 |-> adv_i); // R5
endmodule

bind dma_seq_top dma_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
  .bus_ack_i(bus_ack_i), .bus_addr_o(bus_addr_o), .bus_size_o(bus_size_o),
  .en_o(en_o), .done_o(done_o), .adv_i(cfg_adv)
);

// File: tb/sim_dma_seq_top.sv
`timescale 1ns/1ps
module sim_dma_seq_top;
  localparam logic [31:0] KEY = 32'hA5C3_0000;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
    string       tag;
  } op_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, trig = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req, we, ack, en, done;
  logic [31:0] addr, wdata, rdata;
  logic [1:0]  size;

  int checks = 0, errors = 0, done_cnt = 0;
  op_t exp_q[$];

  always #2 clk = ~clk;

  dma_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .trig_i(trig), .bus_req_o(req), .bus_we_o(we),
    .bus_addr_o(addr), .bus_size_o(size), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_ack_i(ack), .en_o(en), .done_o(done)
  );

  // memory model: ack one cycle after request, read data derived from address
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req && !ack;
      rdata <= addr ^ KEY;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) done_cnt++;
    if (rst_n && req && ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected bus op R9/R10/R11", addr, 0);
      end else begin
        op_t e;
        e = exp_q.pop_front();
        chk(we == e.we,     {e.tag, " dir"},  we,   e.we);
        chk(addr == e.addr, {e.tag, " addr"}, addr, e.addr);
        chk(size == e.size, {e.tag, " size R4/R5"}, size, e.size);
        if (e.we) chk(wdata == e.data, {e.tag, " data R6"}, wdata, e.data);
      end
    end
  end

  task automatic push_units(input int n, inout logic [31:0] s, inout logic [31:0] d,
                            input logic [1:0] sz, input string tag);
    for (int i = 0; i < n; i++) begin
      op_t r, w;
      r.we = 1'b0; r.addr = s; r.size = sz; r.data = '0;     r.tag = tag;
      w.we = 1'b1; w.addr = d; w.size = sz; w.data = s ^ KEY; w.tag = tag;
      exp_q.push_back(r);
      exp_q.push_back(w);
      s = s + (32'd1 << sz);
      d = d + (32'd1 << sz);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [1:0] mode, input bit adv, input bit wrd, input bit half,
                       input bit dual, input logic [7:0] blk, input logic [15:0] cnt,
                       input logic [31:0] s, input logic [31:0] d);
    cfg_wr(3'd1, {24'd0, blk});
    cfg_wr(3'd2, {16'd0, cnt});
    cfg_wr(3'd3, s);
    cfg_wr(3'd4, d);
    cfg_wr(3'd0, {25'd0, adv, wrd, half, mode, dual, 1'b1});
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((exp_q.size() != 0 || req) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    int dc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !en && !done, "reset state R1/R11", {req, en, done}, 0);

    // R1 single mode, byte
    s = 32'h100; d = 32'h200;
    setup(2'b00, 0, 0, 0, 1, 8'd0, 16'd2, s, d);
    push_units(1, s, d, 2'd0, "R1 single");
    pulse_trig(); wait_idle();
    chk(en == 1'b1, "R1 still enabled after one unit", en, 1);
    chk(done_cnt == 0, "R1 no done yet", done_cnt, 0);
    push_units(1, s, d, 2'd0, "R1 single second");
    pulse_trig(); wait_idle();
    chk(en == 1'b0, "R9 enable cleared", en, 0);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
    pulse_trig(); wait_idle();
    chk(done_cnt == 1, "R9 trigger after done ignored", done_cnt, 1);

    // R2 successive, half-word
    s = 32'h1000; d = 32'h2000;
    setup(2'b01, 0, 0, 1, 1, 8'd0, 16'd3, s, d);
    push_units(3, s, d, 2'd1, "R2 successive R6");
    pulse_trig(); wait_idle();
    chk(en == 1'b0 && done_cnt == 2, "R2 whole count on one trigger", done_cnt, 2);

    // R3/R5 block, word (half bit also set)
    s = 32'h3000; d = 32'h4000;
    setup(2'b10, 1, 1, 1, 1, 8'd2, 16'd2, s, d);
    push_units(2, s, d, 2'd2, "R3 block R5");
    pulse_trig(); wait_idle();
    chk(en == 1'b1, "R3 counter per block", en, 1);
    push_units(2, s, d, 2'd2, "R3 block second");
    pulse_trig(); wait_idle();
    chk(en == 1'b0 && done_cnt == 3, "R3 done after two blocks", done_cnt, 3);

    // R4 word bit ignored without advanced mode
    s = 32'h5000; d = 32'h6000;
    setup(2'b00, 0, 1, 0, 1, 8'd0, 16'd1, s, d);
    push_units(1, s, d, 2'd0, "R4 byte");
    pulse_trig(); wait_idle();
    chk(done_cnt == 4, "R4 done", done_cnt, 4);

    // R5 advanced mode without word bit -> half
    s = 32'h5100; d = 32'h6100;
    setup(2'b01, 1, 0, 1, 1, 8'd0, 16'd2, s, d);
    push_units(2, s, d, 2'd1, "R5 half");
    pulse_trig(); wait_idle();
    chk(done_cnt == 5, "R5 done", done_cnt, 5);

    // R7 reserved mode acts as single; R8 writes ignored while enabled
    s = 32'h7000; d = 32'h8000;
    setup(2'b11, 0, 0, 0, 1, 8'd5, 16'd2, s, d);
    push_units(1, s, d, 2'd0, "R7 reserved");
    pulse_trig(); wait_idle();
    chk(en == 1'b1, "R7 one unit only", en, 1);
    cfg_wr(3'd3, 32'hDEAD_0000);
    cfg_wr(3'd0, 32'h0);
    chk(en == 1'b1, "R8 enable write ignored", en, 1);
    push_units(1, s, d, 2'd0, "R8 old source kept");
    pulse_trig(); wait_idle();
    chk(done_cnt == 6, "R7 done", done_cnt, 6);

    // R10 triggers during a job collapse to one pending
    s = 32'h9000; d = 32'hA000;
    setup(2'b00, 0, 0, 0, 1, 8'd0, 16'd3, s, d);
    push_units(2, s, d, 2'd0, "R10 pending");
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); @(negedge clk); trig = 1'b0;
    wait_idle();
    chk(en == 1'b1, "R10 single pending job", en, 1);
    push_units(1, s, d, 2'd0, "R10 last");
    pulse_trig(); wait_idle();
    chk(done_cnt == 7, "R10 done", done_cnt, 7);

    // R3 block length 0 means 256
    s = 32'hB000; d = 32'hC000;
    setup(2'b10, 0, 0, 0, 1, 8'd0, 16'd1, s, d);
    push_units(256, s, d, 2'd0, "R3 blk0");
    pulse_trig(); wait_idle();
    chk(done_cnt == 8, "R3 256-unit block", done_cnt, 8);

    // R11 dual bit clear: trigger ignored
    dc = done_cnt;
    setup(2'b01, 0, 0, 0, 0, 8'd0, 16'd1, 32'hE000, 32'hF000);
    pulse_trig(); wait_idle();
    chk(en == 1'b1 && done_cnt == dc, "R11 no transfer without dual", done_cnt, dc);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule